// File: doc/BRIEF.md
# Ethernet MAC Interrupt Event Controller

This block collects interrupt events for an Ethernet MAC. The transmit, receive and management engines report an event by pulsing a bit of a 32-bit set vector for one cycle. Each pulse latches into an event register, and the bit stays there until software clears it. A second 32-bit register holds a per-bit enable. Each event that the MAC defines has its own interrupt output line. A line is high when both its event bit and its enable bit are set.

Software reaches the block through a plain register bus: a write strobe, a read strobe, a byte address, write data and read data. The event register is write-one-to-clear. The enable register is written directly. There are two more command writes. One asks for a graceful stop, and this raises the graceful-stop event at once. The other reinitialises both registers. When a hardware set and a software clear hit the same bit in one cycle, the set wins, so no event can be lost.

Top module: `mac_irq_ctrl`

## Requirements
- R1: After reset, both registers read zero and all thirteen interrupt lines are low.
- R2: A one in bit n of `evt_set` sets event bit n, and the bit stays set until software clears it. The MAC's events sit at these bits: underrun 19, retry limit 20, late collision 21, bus error 22, management done 23, receive buffer 24, receive frame 25, transmit buffer 26, transmit frame 27, graceful stop 28, babbling transmit 29, babbling receive 30, heartbeat 31.
- R3: A write to address 0x004 clears each event bit that is 1 in the write data. It leaves every other event bit as it was.
- R4: If an event bit is set by `evt_set` and cleared by a write in the same cycle, the bit is set after that cycle.
- R5: A write to address 0x008 loads the write data into the enable register unchanged.
- R6: Each interrupt line is driven by the AND of one event bit and the matching enable bit, and it updates one cycle after either of them changes. Lines 0 to 12 carry these events in this order: transmit frame, transmit buffer, underrun, retry limit, receive frame, receive buffer, management done, late collision, heartbeat, graceful stop, bus error, babbling transmit, babbling receive.
- R7: A write to address 0x0C4 with data bit 0 set sets event bit 28. The same write with bit 0 clear changes nothing.
- R8: A write to address 0x024 with data bit 0 set clears both registers. The same write with bit 0 clear changes nothing.
- R9: A read of address 0x004 returns the event register and a read of 0x008 returns the enable register, in the same cycle and with no side effects. A read of any other address returns zero.
- R10: A write to any other address changes neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 10 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| evt_set | input | 32 | One-cycle event set pulses from the MAC engines |
| irq_lines | output | 13 | Per-event interrupt lines, registered |

## Verification
Two functions can act on the same event bit in one cycle: a hardware set pulse and a software write-one-to-clear. The bench provokes this by driving `evt_set` and a clear write at the same clock edge. The write clears that bit together with some unrelated bits. The check reads the register back: the contested bit must still be set, and only the unrelated bits may have cleared. A line is then checked to rise one cycle later.

// File: rtl/mac_irq_pkg.sv
package mac_irq_pkg;
  localparam int DATA_W    = 32;
  localparam int ADDR_W    = 10;
  localparam int NUM_LINES = 13;

  // Register map (byte offsets)
  localparam logic [9:0] OFF_EVT   = 10'h004;
  localparam logic [9:0] OFF_MASK  = 10'h008;
  localparam logic [9:0] OFF_ECTL  = 10'h024;
  localparam logic [9:0] OFF_TXCTL = 10'h0C4;

  localparam int GS_BIT = 28;

  // Event bit carried by each output line
  function automatic int line_bit(input int line);
    case (line)
      0:       return 27;
      1:       return 26;
      2:       return 19;
      3:       return 20;
      4:       return 25;
      5:       return 24;
      6:       return 23;
      7:       return 21;
      8:       return 31;
      9:       return 28;
      10:      return 22;
      11:      return 29;
      default: return 30;
    endcase
  endfunction
endpackage

// File: rtl/mac_irq_regif.sv
module mac_irq_regif
  import mac_irq_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] evt_q,
  input  logic [DW-1:0] mask_q,
  output logic [DW-1:0] clr_vec,
  output logic          mask_we,
  output logic          gs_req,
  output logic          soft_rst,
  output logic [DW-1:0] bus_rdata
);
  logic hit_evt, hit_mask, hit_ectl, hit_txctl;

  assign hit_evt   = (bus_addr == AW'(OFF_EVT));
  assign hit_mask  = (bus_addr == AW'(OFF_MASK));
  assign hit_ectl  = (bus_addr == AW'(OFF_ECTL));
  assign hit_txctl = (bus_addr == AW'(OFF_TXCTL));

  assign clr_vec  = (bus_wr && hit_evt) ? bus_wdata : '0;
  assign mask_we  = bus_wr && hit_mask;
  assign gs_req   = bus_wr && hit_txctl && bus_wdata[0];
  assign soft_rst = bus_wr && hit_ectl && bus_wdata[0];

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (hit_evt)       bus_rdata = evt_q;
      else if (hit_mask) bus_rdata = mask_q;
    end
  end
endmodule

// File: rtl/mac_irq_evtreg.sv
module mac_irq_evtreg
  import mac_irq_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] evt_set,
  input  logic [DW-1:0] clr_vec,
  input  logic          gs_req,
  input  logic          soft_rst,
  input  logic          mask_we,
  input  logic [DW-1:0] mask_wdata,
  output logic [DW-1:0] evt_q,
  output logic [DW-1:0] mask_q
);
  logic [DW-1:0] raise;

  always_comb begin
    raise = evt_set;
    if (gs_req) raise[GS_BIT] = 1'b1;
  end

  // Sets take priority over clears and over the soft reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q <= '0;
    end else if (soft_rst) begin
      evt_q <= raise;
    end else begin
      evt_q <= (evt_q & ~clr_vec) | raise;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (soft_rst) begin
      mask_q <= '0;
    end else if (mask_we) begin
      mask_q <= mask_wdata;
    end
  end
endmodule

// File: rtl/mac_irq_linemap.sv
module mac_irq_linemap
  import mac_irq_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int NL = NUM_LINES
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] evt_q,
  input  logic [DW-1:0] mask_q,
  output logic [NL-1:0] irq_lines
);
  logic [DW-1:0] active;
  logic          unused_bits;

  assign active      = evt_q & mask_q;
  assign unused_bits = ^active;

  for (genvar g = 0; g < NL; g++) begin : g_line
    localparam int SRC = line_bit(g);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_lines[g] <= 1'b0;
      else        irq_lines[g] <= active[SRC];
    end
  end
endmodule

// File: rtl/mac_irq_ctrl.sv
module mac_irq_ctrl
  import mac_irq_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int NL = NUM_LINES
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [DW-1:0] evt_set,
  output logic [NL-1:0] irq_lines
);
  logic [DW-1:0] evt_q, mask_q, clr_vec;
  logic          mask_we, gs_req, soft_rst;

  mac_irq_regif #(.AW(AW), .DW(DW)) u_regif (
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .evt_q     (evt_q),
    .mask_q    (mask_q),
    .clr_vec   (clr_vec),
    .mask_we   (mask_we),
    .gs_req    (gs_req),
    .soft_rst  (soft_rst),
    .bus_rdata (bus_rdata)
  );

  mac_irq_evtreg #(.DW(DW)) u_evtreg (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_set    (evt_set),
    .clr_vec    (clr_vec),
    .gs_req     (gs_req),
    .soft_rst   (soft_rst),
    .mask_we    (mask_we),
    .mask_wdata (bus_wdata),
    .evt_q      (evt_q),
    .mask_q     (mask_q)
  );

  mac_irq_linemap #(.DW(DW), .NL(NL)) u_linemap (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_q     (evt_q),
    .mask_q    (mask_q),
    .irq_lines (irq_lines)
  );
endmodule

// File: rtl/mac_irq_ctrl_chk.sv
module mac_irq_ctrl_chk
  import mac_irq_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int NL = NUM_LINES
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_wr,
  input logic          bus_rd,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic [DW-1:0] bus_rdata,
  input logic [DW-1:0] evt_set,
  input logic [NL-1:0] irq_lines,
  input logic [DW-1:0] evt_q,
  input logic [DW-1:0] mask_q
);
  logic wr_evt, wr_mask, wr_ectl, wr_tx;
  assign wr_evt  = bus_wr && bus_addr == AW'(OFF_EVT);
  assign wr_mask = bus_wr && bus_addr == AW'(OFF_MASK);
  assign wr_ectl = bus_wr && bus_addr == AW'(OFF_ECTL);
  assign wr_tx   = bus_wr && bus_addr == AW'(OFF_TXCTL);

  p_set_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_set != '0) |=> ((evt_q & $past(evt_set)) == $past(evt_set)));

  p_w1c_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_evt && evt_set == '0) |=> (evt_q == ($past(evt_q) & ~$past(bus_wdata))));

  p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_evt && (evt_set & bus_wdata) != '0)
      |=> ((evt_q & $past(evt_set & bus_wdata)) == $past(evt_set & bus_wdata)));

  p_mask_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mask |=> (mask_q == $past(bus_wdata)));

  for (genvar g = 0; g < NL; g++) begin : g_chk
    localparam int SRC = line_bit(g);
    p_line_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ##1 (irq_lines[g] == $past(evt_q[SRC] & mask_q[SRC])));
  end

  p_graceful_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_tx && bus_wdata[0]) |=> evt_q[GS_BIT]);

  p_soft_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ectl && bus_wdata[0] && evt_set == '0) |=> (evt_q == '0 && mask_q == '0));

  p_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == AW'(OFF_EVT)) |-> (bus_rdata == evt_q));

  p_stray_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !wr_evt && !wr_mask && !wr_ectl && !wr_tx && evt_set == '0)
      |=> (evt_q == $past(evt_q) && mask_q == $past(mask_q)));
endmodule

bind mac_irq_ctrl mac_irq_ctrl_chk #(.AW(AW), .DW(DW), .NL(NL)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .evt_set   (evt_set),
  .irq_lines (irq_lines),
  .evt_q     (evt_q),
  .mask_q    (mask_q)
);

// File: tb/mac_irq_ctrl_tb.sv
module mac_irq_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [9:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] evt_set = '0;
  logic [12:0] irq_lines;

  int n_checks = 0;
  int n_fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mac_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt_set(evt_set), .irq_lines(irq_lines)
  );

  // Independent copy of the line order from the requirements
  function automatic int src_of(input int line);
    int tbl [13] = '{27, 26, 19, 20, 25, 24, 23, 21, 31, 28, 22, 29, 30};
    return tbl[line];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0; bus_addr = '0;
  endtask

  task automatic bus_read(input logic [9:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    #1;
    d = bus_rdata;
    bus_rd = 1'b0; bus_addr = '0;
  endtask

  task automatic pulse_set(input logic [31:0] v);
    @(negedge clk);
    evt_set = v;
    @(posedge clk);
    @(negedge clk);
    evt_set = '0;
  endtask

  task automatic wait_line();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    bus_read(10'h004, d); chk("R1 event reg", d, 32'h0);
    bus_read(10'h008, d); chk("R1 mask reg", d, 32'h0);
    chk("R1 lines", {19'h0, irq_lines}, 32'h0);
  endtask

  task automatic t_line_map();
    logic [31:0] d;
    bus_write(10'h008, 32'hFFFF_FFFF);
    for (int i = 0; i < 13; i++) begin
      pulse_set(32'h1 << src_of(i));
      bus_read(10'h004, d);
      chk($sformatf("R2 sticky bit %0d", src_of(i)), d, 32'h1 << src_of(i));
      wait_line();
      chk($sformatf("R6 line %0d", i), {19'h0, irq_lines}, 32'h1 << i);
      bus_write(10'h004, 32'hFFFF_FFFF);
      wait_line();
    end
    chk("R6 lines low after clear", {19'h0, irq_lines}, 32'h0);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    pulse_set(32'hFFF8_0000);
    bus_write(10'h008, 32'h0A00_0000);
    bus_read(10'h008, d); chk("R5 mask readback", d, 32'h0A00_0000);
    wait_line();
    // bits 27 -> line 0, 25 -> line 4
    chk("R6 masked lines", {19'h0, irq_lines}, 32'h0000_0011);
    bus_write(10'h008, 32'h0);
    wait_line();
    chk("R6 all masked", {19'h0, irq_lines}, 32'h0);
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    bus_write(10'h004, 32'hFFFF_FFFF);
    pulse_set(32'hA5F0_000F);
    bus_write(10'h004, 32'h8470_0005);
    bus_read(10'h004, d); chk("R3 partial clear", d, 32'h2180_000A);
    bus_write(10'h004, 32'h0);
    bus_read(10'h004, d); chk("R3 zero write", d, 32'h2180_000A);
  endtask

  task automatic t_collision();
    logic [31:0] d;
    bus_write(10'h004, 32'hFFFF_FFFF);
    pulse_set(32'h0300_0000);
    bus_write(10'h008, 32'hFFFF_FFFF);
    wait_line();
    @(negedge clk);
    evt_set = 32'h0200_0000;
    bus_wr = 1'b1; bus_addr = 10'h004; bus_wdata = 32'h0300_0000;
    @(posedge clk);
    @(negedge clk);
    evt_set = '0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    bus_read(10'h004, d); chk("R4 set wins", d, 32'h0200_0000);
    wait_line();
    // bit 25 -> line 4 stays, bit 24 -> line 5 drops
    chk("R4 lines after collision", {19'h0, irq_lines}, 32'h0000_0010);
  endtask

  task automatic t_graceful();
    logic [31:0] d;
    bus_write(10'h004, 32'hFFFF_FFFF);
    bus_write(10'h0C4, 32'h0000_0002);
    bus_read(10'h004, d); chk("R7 bit0 clear no effect", d, 32'h0);
    bus_write(10'h0C4, 32'h0000_0001);
    bus_read(10'h004, d); chk("R7 graceful stop raised", d, 32'h1000_0000);
    wait_line();
    chk("R7 line 9", {19'h0, irq_lines}, 32'h0000_0200);
  endtask

  task automatic t_soft_reset();
    logic [31:0] d;
    pulse_set(32'h0008_0000);
    bus_write(10'h024, 32'h0000_0002);
    bus_read(10'h004, d); chk("R8 bit0 clear keeps events", d, 32'h1008_0000);
    bus_read(10'h008, d); chk("R8 bit0 clear keeps mask", d, 32'hFFFF_FFFF);
    bus_write(10'h024, 32'h0000_0001);
    bus_read(10'h004, d); chk("R8 events cleared", d, 32'h0);
    bus_read(10'h008, d); chk("R8 mask cleared", d, 32'h0);
    wait_line();
    chk("R8 lines low", {19'h0, irq_lines}, 32'h0);
  endtask

  task automatic t_other();
    logic [31:0] d, d2;
    bus_write(10'h008, 32'h1234_5678);
    pulse_set(32'h4000_0000);
    bus_write(10'h010, 32'hFFFF_FFFF);
    bus_write(10'h000, 32'hFFFF_FFFF);
    bus_write(10'h184, 32'hFFFF_FFFF);
    bus_read(10'h004, d); chk("R10 events unchanged", d, 32'h4000_0000);
    bus_read(10'h008, d); chk("R10 mask unchanged", d, 32'h1234_5678);
    bus_read(10'h004, d2); chk("R9 repeated read", d2, 32'h4000_0000);
    bus_read(10'h0E4, d); chk("R9 unmapped reads zero", d, 32'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_line_map();
    t_mask();
    t_w1c();
    t_collision();
    t_graceful();
    t_soft_reset();
    t_other();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule